// File: doc/BRIEF.md
# Power-State Wakelock Request Controller

This block sits beside a display power controller and lets software hold the display engine awake. Software writes a request bit into one of a bank of independent lock registers. While the wakelock mode is switched on and at least one deep low-power state is permitted, any held request raises a power-state exit request toward the power controller. The engine stays out of the low-power state for as long as any request is held. The power controller answers with a power-good level. Each lock then reports an acknowledge bit, which software polls before it touches registers that lose power in the deep states.

Re-entry to the low-power state is allowed only when no effective request remains. The block signals this by dropping the exit request. Turning the wakelock mode off clears every request bit. The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure: every write lands on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` in the same cycle.

Top module: `wl_ctrl`

## Requirements
- R1: After reset the enable bit, every request bit and every acknowledge bit read 0, and `exit_req` is low.
- R2: Address 0 is the configuration register. Bit 0 is the wakelock-mode enable: it can be read and written, and all other bits read 0.
- R3: Addresses 1 to NUM_LOCKS are lock registers. Bit 0 is the request bit: it can be read and written, and each lock holds its own value independently of the others.
- R4: `exit_req` is high in the same cycle in which at least one request bit is 1, the enable bit is 1 and at least one bit of `deep_allow` is 1. It is low otherwise.
- R5: A lock's acknowledge bit (bit 1) reads 1 once a clock edge has seen, at the same time, its request held, the mode active and `pwr_good` high. Writes to bit 1 are ignored.
- R6: The acknowledge bit reads 0 from the cycle after the request is cleared. It also reads 0 one edge after `pwr_good` falls.
- R7: Writing 0 to the enable bit clears every lock's request bit on the same edge.
- R8: A request written while the mode is off is kept. It raises `exit_req` as soon as the mode is enabled.
- R9: Addresses above NUM_LOCKS read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| deep_allow | input | NUM_DEEP | One bit per permitted deep low-power state |
| pwr_good | input | 1 | Engine powered indication from the power controller |
| exit_req | output | 1 | Request to leave, and stay out of, the low-power state |

## Verification
The bench builds the block with its defaults: 13 locks, three deep-state permission bits, a 5-bit address and 32-bit data. With these values both the first and the last lock address can be reached, and so can address 14, the first address outside the map. This lets the bench show that locks stay independent across the whole bank. It also lets it check which `deep_allow` bit opens the gate, and that an out-of-range access has no effect.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned CFG_ADDR = 0;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_REQ  = 0;
  localparam int unsigned BIT_ACK  = 1;
endpackage

// File: rtl/wl_cfg_reg.sv
module wl_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_en_bit,
  output logic en_o,
  output logic clr_all_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else if (wr_hit) en_q <= wr_en_bit;
  end

  assign en_o      = en_q;
  assign clr_all_o = wr_hit && !wr_en_bit;

  AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (en_q == $past(wr_en_bit)));  // R2
endmodule

// File: rtl/wl_lock_slot.sv
module wl_lock_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_req_bit,
  input  logic clr_all,
  input  logic active,
  input  logic pwr_good,
  output logic req_o,
  output logic ack_o,
  output logic hold_o
);
  logic req_q;
  logic ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      if (clr_all) req_q <= 1'b0;
      else if (wr_hit) req_q <= wr_req_bit;
      ack_q <= req_q && active && pwr_good;
    end
  end

  assign req_o  = req_q;
  assign ack_o  = ack_q && req_q;
  assign hold_o = req_q && active;

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> req_o);  // R6
  AST_ACK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(pwr_good));  // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !req_q);  // R7
endmodule

// File: rtl/wl_ctrl.sv
module wl_ctrl #(
  parameter int unsigned NUM_LOCKS = 13,
  parameter int unsigned NUM_DEEP  = 3,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_DEEP-1:0] deep_allow,
  input  logic              pwr_good,
  output logic              exit_req
);
  import wl_pkg::*;

  localparam int unsigned LAST_ADDR = NUM_LOCKS;

  logic en;
  logic clr_all;
  logic active;
  logic [NUM_LOCKS-1:0] req_v;
  logic [NUM_LOCKS-1:0] ack_v;
  logic [NUM_LOCKS-1:0] hold_v;
  logic unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata[DATA_W-1:1];

  wl_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (reg_wr && (reg_addr == ADDR_W'(CFG_ADDR))),
    .wr_en_bit (reg_wdata[BIT_EN]),
    .en_o      (en),
    .clr_all_o (clr_all)
  );

  assign active = en && (|deep_allow);

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_slot
    wl_lock_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (reg_wr && (reg_addr == ADDR_W'(g + 1))),
      .wr_req_bit (reg_wdata[BIT_REQ]),
      .clr_all    (clr_all),
      .active     (active),
      .pwr_good   (pwr_good),
      .req_o      (req_v[g]),
      .ack_o      (ack_v[g]),
      .hold_o     (hold_v[g])
    );
  end

  assign exit_req = |hold_v;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CFG_ADDR)) reg_rdata[BIT_EN] = en;
    for (int i = 0; i < NUM_LOCKS; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) begin
        reg_rdata[BIT_REQ] = req_v[i];
        reg_rdata[BIT_ACK] = ack_v[i];
      end
    end
  end

  AST_EXIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> (en && (|deep_allow) && (|req_v)));  // R4
  AST_IDLE_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v == '0) |-> !exit_req);  // R4
  AST_ACK_WITHIN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(LAST_ADDR)) |-> (reg_rdata == '0));  // R9
endmodule

// File: tb/sim_wl_ctrl.sv
module sim_wl_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [2:0] deep_allow = '0;
  logic pwr_good = 0;
  logic exit_req;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deep_allow(deep_allow),
    .pwr_good(pwr_good), .exit_req(exit_req)
  );

  typedef struct packed {
    logic [4:0] addr;
    logic [1:0] wdata;
    logic [2:0] deep;
    logic       pg;
    logic [1:0] exp_rd;
    logic       exp_exit;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  2'd1, 3'd1, 1'b0, 2'd1, 1'b0},
    '{5'd1,  2'd1, 3'd1, 1'b0, 2'd1, 1'b1},
    '{5'd1,  2'd1, 3'd1, 1'b1, 2'd3, 1'b1},
    '{5'd13, 2'd1, 3'd2, 1'b1, 2'd3, 1'b1},
    '{5'd1,  2'd0, 3'd2, 1'b1, 2'd0, 1'b1},
    '{5'd13, 2'd0, 3'd2, 1'b1, 2'd0, 1'b0},
    '{5'd5,  2'd3, 3'd0, 1'b1, 2'd1, 1'b0},
    '{5'd5,  2'd1, 3'd4, 1'b1, 2'd3, 1'b1},
    '{5'd0,  2'd0, 3'd4, 1'b1, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 cfg", 5'd0, 0);
    rd_chk("R1 lock1", 5'd1, 0);
    rd_chk("R1 lock13", 5'd13, 0);
    chk("R1 exit", {31'b0, exit_req}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      deep_allow = VECS[i].deep; pwr_good = VECS[i].pg;
      reg_wr = 1; reg_addr = VECS[i].addr; reg_wdata = {30'b0, VECS[i].wdata};
      @(negedge clk);
      reg_wr = 0;
      @(negedge clk);
      rd_chk($sformatf("R2/R3/R5 vec%0d rd", i), VECS[i].addr, {30'b0, VECS[i].exp_rd});
      chk($sformatf("R4 vec%0d exit", i), {31'b0, exit_req}, {31'b0, VECS[i].exp_exit});
    end
    // R7 disable cleared lock5
    rd_chk("R7 lock5 cleared", 5'd5, 0);

    // R8 request held while disabled, effective on enable
    deep_allow = 3'd1; pwr_good = 0;
    wr(5'd7, 1);
    rd_chk("R8 held while off", 5'd7, 1);
    chk("R8 no exit while off", {31'b0, exit_req}, 0);
    wr(5'd0, 1);
    chk("R8 exit on enable", {31'b0, exit_req}, 1);

    // R5/R6 ack with pwr_good, drop on pwr_good fall
    pwr_good = 1;
    @(negedge clk);
    rd_chk("R5 ack after power", 5'd7, 3);
    pwr_good = 0;
    @(negedge clk);
    rd_chk("R6 ack drops on power loss", 5'd7, 1);
    pwr_good = 1;
    @(negedge clk);
    rd_chk("R5 ack again", 5'd7, 3);
    // R6 ack drops on the cycle after request clear
    wr(5'd7, 0);
    rd_chk("R6 ack drops with request", 5'd7, 0);
    chk("R4 exit idle", {31'b0, exit_req}, 0);

    // R3 independence: two locks, clear one
    wr(5'd2, 1);
    wr(5'd3, 1);
    wr(5'd2, 0);
    rd_chk("R3 lock2 clear", 5'd2, 0);
    rd_chk("R3 lock3 kept", 5'd3, 3);
    chk("R4 exit from lock3", {31'b0, exit_req}, 1);
    deep_allow = 3'd0;
    #1;
    chk("R4 exit needs deep", {31'b0, exit_req}, 0);
    deep_allow = 3'd1;

    // R9 out of range
    wr(5'd14, 32'hFFFF_FFFF);
    rd_chk("R9 read 14", 5'd14, 0);
    rd_chk("R9 read 31", 5'd31, 0);
    rd_chk("R9 cfg untouched", 5'd0, 1);
    rd_chk("R9 lock13 untouched", 5'd13, 0);
    rd_chk("R9 lock3 untouched", 5'd3, 3);

    summary();
  end
endmodule